// File: doc/BRIEF.md
# Receive Byte-Count Capture on Slave Deselect

This block sits beside the receive DMA of an SPI slave port. When the remote master releases slave select (a low-to-high transition of the active-low select line), it copies the byte count of whichever receive buffer is active into a saved-count register. Software can then tell how many bytes of the finished transaction landed in memory. Only the first release after a buffer is loaded is captured. Any later release before the next load leaves the saved count alone and sets a flag instead.

A 3-bit status field shows whether a count was taken, which buffer it came from, and whether an extra release was seen. Loading either buffer clears the status and arms the capture again. The select input is expected to be synchronized already. The block registers it once more to find the edge. The counts, the active-buffer flags and the load pulses come from the DMA engine, which is not part of this block.

Top module: `rx_cnt_capture`

## Requirements
- R1: While reset is held and after it is released, `savedCnt` is 0, `capStatus` is 3'b000, and capture is not armed.
- R2: A rising edge is seen on a clock edge where `selN` is 1 and it was 0 at the previous clock edge. If that happens while capture is armed, `rxActive`=1 and `rxBufSel`=0 (buffer A), then on that same clock edge `savedCnt` takes `cntA`, `capStatus[0]` (buffer A saved) sets, and capture disarms.
- R3: The same rising edge while armed with `rxActive`=1 and `rxBufSel`=1 (buffer B) loads `cntB` into `savedCnt`, sets `capStatus[1]` (buffer B saved) and disarms.
- R4: After a capture, further rising edges before the next load never change `savedCnt`, even when the counts change.
- R5: A rising edge while capture is not armed sets `capStatus[2]` (extra edge) and leaves bits 1:0 and `savedCnt` unchanged. This includes edges before the first load after reset.
- R6: A pulse on `loadA` or `loadB` clears `capStatus` to 3'b000 and arms capture. `savedCnt` is kept.
- R7: A falling edge of `selN`, or `selN` held at either level, changes neither output.
- R8: A rising edge while armed with `rxActive`=0 saves nothing, changes no status bit, and leaves capture armed for the next edge.
- R9: When a load pulse and a rising edge occur on the same clock edge, the load wins. The status is cleared, capture is armed, and the edge is otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selN | input | 1 | Synchronized slave select, active low |
| loadA | input | 1 | One-cycle pulse: buffer A loaded |
| loadB | input | 1 | One-cycle pulse: buffer B loaded |
| rxActive | input | 1 | A receive buffer is currently active |
| rxBufSel | input | 1 | Active buffer: 0 = A, 1 = B |
| cntA | input | 16 | Byte count of buffer A |
| cntB | input | 16 | Byte count of buffer B |
| savedCnt | output | 16 | Count captured at the first release after a load |
| capStatus | output | 3 | bit0 A saved, bit1 B saved, bit2 extra edge |

## Verification
The hardest case to reach is a release that arrives while capture is armed but no buffer is active. The capture must then stay armed, and the next release must still take the count. The stimulus loads a buffer, drops `rxActive`, toggles select, raises `rxActive` again and toggles once more. A second hard case is a load pulse that lands on the very clock edge where select rises. The bench sets up this collision by driving both inputs in the same cycle. Every cycle is compared against a behavioural model of the arm flag and the status bits.

// File: rtl/rx_cnt_capture_pkg.sv
package rx_cnt_capture_pkg;
  localparam int STAT_W = 3;
  localparam int BIT_A = 0;
  localparam int BIT_B = 1;
  localparam int BIT_EXTRA = 2;

  typedef struct packed {
    logic clearStatus;
    logic captureA;
    logic captureB;
    logic markExtra;
  } capStrobes_t;
endpackage

// File: rtl/rx_cnt_capture_ctrl.sv
module rx_cnt_capture_ctrl
  import rx_cnt_capture_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        loadA,
  input  logic        loadB,
  input  logic        rxActive,
  input  logic        rxBufSel,
  output capStrobes_t strb
);
  logic selPrev;
  logic armed;
  logic selRise;
  logic anyLoad;

  assign selRise = selN && !selPrev;
  assign anyLoad = loadA || loadB;

  always_comb begin
    strb.clearStatus = anyLoad;
    strb.captureA    = !anyLoad && selRise && armed && rxActive && !rxBufSel;
    strb.captureB    = !anyLoad && selRise && armed && rxActive && rxBufSel;
    strb.markExtra   = !anyLoad && selRise && !armed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selPrev <= 1'b1;
      armed   <= 1'b0;
    end else begin
      selPrev <= selN;
      if (anyLoad)
        armed <= 1'b1;
      else if (strb.captureA || strb.captureB)
        armed <= 1'b0;
    end
  end

  // R2 R3 R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.captureA, strb.captureB, strb.markExtra}));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadA || loadB) |-> !(strb.captureA || strb.captureB || strb.markExtra));

  // R4
  disarm_after_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.captureA || strb.captureB) |=> !armed);

  // R8
  stay_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !rxActive && !loadA && !loadB) |=> armed);
endmodule

// File: rtl/rx_cnt_capture_dp.sv
module rx_cnt_capture_dp
  import rx_cnt_capture_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobes_t       strb,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  output logic [CNT_W-1:0]  savedCnt,
  output logic [STAT_W-1:0] capStatus
);
  always_ff @(posedge clk) begin
    if (!rstN)
      savedCnt <= '0;
    else if (strb.captureA)
      savedCnt <= cntA;
    else if (strb.captureB)
      savedCnt <= cntB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capStatus <= '0;
    end else if (strb.clearStatus) begin
      capStatus <= '0;
    end else begin
      if (strb.captureA)  capStatus[BIT_A]     <= 1'b1;
      if (strb.captureB)  capStatus[BIT_B]     <= 1'b1;
      if (strb.markExtra) capStatus[BIT_EXTRA] <= 1'b1;
    end
  end

  // R4 R7
  saved_only_on_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (savedCnt != $past(savedCnt)) |-> $past(strb.captureA || strb.captureB));

  // R6
  clear_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearStatus |=> (capStatus == '0));

  // R2 R3
  single_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(capStatus[BIT_A] && capStatus[BIT_B]));
endmodule

// File: rtl/rx_cnt_capture.sv
module rx_cnt_capture
  import rx_cnt_capture_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              loadA,
  input  logic              loadB,
  input  logic              rxActive,
  input  logic              rxBufSel,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  output logic [CNT_W-1:0]  savedCnt,
  output logic [STAT_W-1:0] capStatus
);
  capStrobes_t strb;

  rx_cnt_capture_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .loadA(loadA), .loadB(loadB),
    .rxActive(rxActive), .rxBufSel(rxBufSel), .strb(strb)
  );

  rx_cnt_capture_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntA(cntA), .cntB(cntB),
    .savedCnt(savedCnt), .capStatus(capStatus)
  );
endmodule

// File: tb/test_rx_cnt_capture.sv
`timescale 1ns/1ps
module test_rx_cnt_capture;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, loadA = 1'b0, loadB = 1'b0, rxActive = 1'b0, rxBufSel = 1'b0;
  logic [15:0] cntA = '0, cntB = '0;
  logic [15:0] savedCnt;
  logic [2:0] capStatus;

  int vectors = 0;
  int fails = 0;
  string curReq = "R1";

  int mSaved = 0;
  int mStatus = 0;
  bit mArmed = 0;
  bit mPrev = 1;

  always #4 clk = ~clk;

  rx_cnt_capture i_rx_cnt_capture (
    .clk(clk), .rstN(rstN), .selN(selN), .loadA(loadA), .loadB(loadB),
    .rxActive(rxActive), .rxBufSel(rxBufSel), .cntA(cntA), .cntB(cntB),
    .savedCnt(savedCnt), .capStatus(capStatus)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mSaved = 0; mStatus = 0; mArmed = 0; mPrev = 1;
    end else begin
      bit rise;
      rise = selN && !mPrev;
      mPrev = selN;
      if (loadA || loadB) begin
        mStatus = 0; mArmed = 1;
      end else if (rise) begin
        if (!mArmed) mStatus = mStatus | 4;
        else if (rxActive) begin
          mSaved = rxBufSel ? int'(cntB) : int'(cntA);
          mStatus = mStatus | (rxBufSel ? 2 : 1);
          mArmed = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN || curReq == "R1") begin
      vectors++;
      if (int'(savedCnt) != mSaved || int'(capStatus) != mStatus) begin
        fails++;
        $display("FAIL %s model: saved=%h status=%b expected saved=%h status=%b",
                 curReq, savedCnt, capStatus, mSaved[15:0], mStatus[2:0]);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic check(string req, int act, int exp);
    @(negedge clk); #1;
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseLoad(bit b);
    if (b) loadB = 1; else loadA = 1;
    tick(); loadA = 0; loadB = 0;
  endtask

  task automatic release_sel();
    selN = 0; tick(2); selN = 1; tick();
  endtask

  initial begin
    #200_000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1", savedCnt, 0);
    check("R1", capStatus, 0);
    rstN = 1; tick(2);
    check("R1", capStatus, 0);

    curReq = "R5";
    release_sel();
    check("R5", capStatus, 3'b100);
    check("R5", savedCnt, 0);

    curReq = "R2";
    cntA = 16'h1234; rxActive = 1; rxBufSel = 0;
    pulseLoad(0);
    check("R6", capStatus, 0);
    release_sel();
    check("R2", savedCnt, 16'h1234);
    check("R2", capStatus, 3'b001);

    curReq = "R4";
    cntA = 16'h5555;
    release_sel();
    check("R4", savedCnt, 16'h1234);
    check("R5", capStatus, 3'b101);

    curReq = "R7";
    selN = 0; cntA = 16'h7777; tick(4);
    check("R7", savedCnt, 16'h1234);
    check("R7", capStatus, 3'b101);
    selN = 1; tick(); selN = 0; tick(); // falling edge then rise on next
    selN = 1; tick(3);

    curReq = "R3";
    cntB = 16'hBEEF; rxBufSel = 1;
    pulseLoad(1);
    check("R6", capStatus, 0);
    release_sel();
    check("R3", savedCnt, 16'hBEEF);
    check("R3", capStatus, 3'b010);

    curReq = "R8";
    rxActive = 0; cntA = 16'h0A0A; rxBufSel = 0;
    pulseLoad(0);
    release_sel();
    check("R8", savedCnt, 16'hBEEF);
    check("R8", capStatus, 0);
    rxActive = 1;
    release_sel();
    check("R8", savedCnt, 16'h0A0A);
    check("R8", capStatus, 3'b001);

    curReq = "R9";
    cntA = 16'h3C3C;
    selN = 0; tick(2);
    selN = 1; loadA = 1; tick(); loadA = 0;
    check("R9", capStatus, 0);
    check("R9", savedCnt, 16'h0A0A);
    release_sel();
    check("R9", savedCnt, 16'h3C3C);
    check("R9", capStatus, 3'b001);

    curReq = "R5";
    loadB = 1; tick(); loadB = 0; tick(); // load with select already high
    release_sel(); release_sel();
    check("R5", capStatus, 3'b101);
    tick(3);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule